// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block gathers thirteen level-sensitive interrupt request lines from board peripherals. Each line lands on a fixed bit of a 16-bit pending word. That word is gated by a software-controlled enable mask, and the active source with the smallest priority level is turned into a 4-bit inverted level code for the processor's encoded interrupt input. A code of zero means that no interrupt is being requested.

The same block provides a small 16-bit register window of 64 bytes. The window holds the enable mask, a general-purpose output port, a constant version word and a power-off control. The power-off control does not act on the system itself. It raises a one-clock request pulse, and logic outside the block carries out the shutdown.

Top module: `board_irl_enc`

## Requirements
- R1: Sources use fixed pending-bit positions, and each source's priority level equals its index. The source-to-bit pairs are 0→11, 1→9, 2→8, 3→12, 4→10, 5→6, 6→5, 7→4, 8→7, 9→14, 10→13, 11→0 and 12→15. A pending bit is 1 exactly while its input is high.
- R2: A source takes part in encoding only when both its pending bit and the mask bit at the same position are 1.
- R3: Among the sources that take part, the smallest level wins. When no source takes part, the selected level is 15.
- R4: `irl_code` is the selected level XOR 15, so it is 0 when nothing is active. It is registered and reflects the inputs one clock edge after they are applied.
- R5: A write to the mask takes effect on `irl_code` at the same clock edge that stores the new mask.
- R6: The mask (byte offset 0x00) and the output port (offset 0x36) are 16-bit read/write registers. The output port value drives `gpo`.
- R7: The version register (offset 0x32) always reads 0x0010, and writes to it change nothing.
- R8: The power-off register (offset 0x30) always reads 0. A write with bit 0 set produces a one-clock `shutdown_req` pulse after the write edge. A write with bit 0 clear produces no pulse.
- R9: Reads from any other offset, odd offsets included, return 0. Writes to other offsets change no register.
- R10: Reset clears the mask, the output port, `irl_code` and `shutdown_req`.
- R11: `bus_rdata` is 0 whenever no read access is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 13 | Level interrupt requests, index = source |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irl_code | output | 4 | Inverted winning level, 0 = idle |
| gpo | output | 16 | General output port value |
| shutdown_req | output | 1 | One-clock power-off request |

## Verification
The bench sweeps every one of the 8192 input patterns under several masks. A design with a swapped bit pair, or one that picks the largest level instead of the smallest, gives the wrong code on many of those patterns. It also checks that a mask write moves the code at the very edge that stores it; a design that encodes from the old mask lags by one clock and is caught there. Writes to the version register and to unused or odd offsets are followed by readbacks of every register, which exposes a decoder that aliases addresses. Power-off writes with bit 0 set and with bit 0 clear confirm that the pulse appears only in the first case and lasts exactly one clock.

// File: rtl/board_irl_enc.sv
module board_irl_enc #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int LW = 4,
  parameter logic [DW-1:0] VERSION = 16'h0010,
  parameter logic [AW-1:0] OFF_MASK = 6'h00,
  parameter logic [AW-1:0] OFF_PWR  = 6'h30,
  parameter logic [AW-1:0] OFF_VER  = 6'h32,
  parameter logic [AW-1:0] OFF_GPO  = 6'h36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [12:0]   irq_lines,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic [LW-1:0] irl_code,
  output logic [DW-1:0] gpo,
  output logic          shutdown_req
);
  localparam int NSRC = 13;
  localparam logic [LW-1:0] NONE = '1;

  function automatic int src_bit(input int s);
    case (s)
      0: return 11;  1: return 9;   2: return 8;   3: return 12;
      4: return 10;  5: return 6;   6: return 5;   7: return 4;
      8: return 7;   9: return 14;  10: return 13; 11: return 0;
      default: return 15;
    endcase
  endfunction

  logic [DW-1:0] pend, mask_q, mask_nx;
  logic [LW-1:0] win;
  logic          wr_mask, wr_gpo, wr_pwr, rd_acc;

  assign wr_mask = bus_sel && bus_we && bus_addr == OFF_MASK;
  assign wr_gpo  = bus_sel && bus_we && bus_addr == OFF_GPO;
  assign wr_pwr  = bus_sel && bus_we && bus_addr == OFF_PWR;
  assign rd_acc  = bus_sel && !bus_we;
  assign mask_nx = wr_mask ? bus_wdata : mask_q;

  always_comb begin
    pend = '0;
    for (int s = 0; s < NSRC; s++) pend[src_bit(s)] = irq_lines[s];
  end

  always_comb begin
    win = NONE;
    for (int s = NSRC - 1; s >= 0; s--)
      if (pend[src_bit(s)] && mask_nx[src_bit(s)]) win = LW'(s);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q       <= '0;
      gpo          <= '0;
      irl_code     <= '0;
      shutdown_req <= 1'b0;
    end else begin
      mask_q       <= mask_nx;
      if (wr_gpo) gpo <= bus_wdata;
      irl_code     <= win ^ NONE;
      shutdown_req <= wr_pwr && bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (bus_addr)
        OFF_MASK: bus_rdata = mask_q;
        OFF_GPO:  bus_rdata = gpo;
        OFF_VER:  bus_rdata = VERSION;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R4
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines == '0) |=> (irl_code == '0));

  // R6
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(bus_wdata)));

  // R8
  pwr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(bus_sel && bus_we && bus_addr == OFF_PWR));

  // R7
  version_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == OFF_VER) |-> (bus_rdata == VERSION));

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |-> (bus_rdata == '0));
endmodule

// File: tb/board_irl_enc_tb.sv
module board_irl_enc_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [12:0] irq_lines = '0;
  logic        bus_sel = 0, bus_we = 0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, gpo;
  logic [3:0]  irl_code;
  logic        shutdown_req;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  board_irl_enc u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irl_code(irl_code), .gpo(gpo), .shutdown_req(shutdown_req)
  );

  function automatic int tb_bit(input int s);
    int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
    return t[s];
  endfunction

  function automatic logic [15:0] expect_code(input logic [12:0] irq, input logic [15:0] m);
    for (int s = 0; s < 13; s++)
      if (irq[s] && m[tb_bit(s)]) return 16'(s ^ 15);
    return 16'h0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic sweep_all(input logic [15:0] m, input string req);
    wr(6'h00, m);
    for (int p = 0; p < 8192; p++) begin
      irq_lines = 13'(p);
      @(negedge clk);
      chk(req, 16'(irl_code), expect_code(13'(p), m));
    end
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 code", 16'(irl_code), 16'h0);
    chk("R10 gpo", gpo, 16'h0);
    chk("R10 shut", 16'(shutdown_req), 16'h0);
    chk("R11 idle rdata", bus_rdata, 16'h0);
    rst_n = 1;
    @(negedge clk);
    rd(6'h00, d); chk("R10 mask", d, 16'h0);

    // R2 mask zero blocks everything
    irq_lines = '1;
    @(negedge clk);
    chk("R2 mask zero", 16'(irl_code), 16'h0);

    // R1 R3 R4 full sweeps
    sweep_all(16'hFFFF, "R1_R3_R4 full mask");
    sweep_all(16'h5555, "R2 mask 5555");
    sweep_all(16'hAAAA, "R2 mask AAAA");

    // R1 single-bit masks against single sources and all-on
    for (int b = 0; b < 16; b++) begin
      wr(6'h00, 16'(1) << b);
      for (int s = 0; s < 13; s++) begin
        irq_lines = 13'(1) << s;
        @(negedge clk);
        chk("R1 single map", 16'(irl_code), expect_code(13'(1) << s, 16'(1) << b));
      end
      irq_lines = '1;
      @(negedge clk);
      chk("R3 all on", 16'(irl_code), expect_code('1, 16'(1) << b));
    end

    // R5 mask write takes effect at the storing edge
    wr(6'h00, 16'h0000);
    irq_lines = 13'h0001;
    @(negedge clk);
    chk("R5 before", 16'(irl_code), 16'h0);
    wr(6'h00, 16'h0800);
    chk("R5 same edge", 16'(irl_code), 16'h000F);
    wr(6'h00, 16'h0000);
    chk("R5 unmask", 16'(irl_code), 16'h0);

    // R6 readback and gpo
    wr(6'h00, 16'hBEEF); rd(6'h00, d); chk("R6 mask rd", d, 16'hBEEF);
    wr(6'h36, 16'h1234); rd(6'h36, d); chk("R6 gpo rd", d, 16'h1234);
    chk("R6 gpo pin", gpo, 16'h1234);

    // R7 version
    wr(6'h32, 16'hFFFF); rd(6'h32, d); chk("R7 version", d, 16'h0010);
    rd(6'h00, d); chk("R7 mask kept", d, 16'hBEEF);
    rd(6'h36, d); chk("R7 gpo kept", d, 16'h1234);

    // R8 power-off
    wr(6'h30, 16'h0001);
    chk("R8 pulse", 16'(shutdown_req), 16'h1);
    @(negedge clk);
    chk("R8 pulse end", 16'(shutdown_req), 16'h0);
    wr(6'h30, 16'hFFFE);
    chk("R8 no pulse", 16'(shutdown_req), 16'h0);
    rd(6'h30, d); chk("R8 reads zero", d, 16'h0);

    // R9 other offsets
    for (int a = 0; a < 64; a++) begin
      if (a != 6'h00 && a != 6'h30 && a != 6'h32 && a != 6'h36) begin
        wr(6'(a), 16'h5A5A);
        rd(6'(a), d); chk("R9 unused rd", d, 16'h0);
      end
    end
    rd(6'h00, d); chk("R9 mask kept", d, 16'hBEEF);
    rd(6'h36, d); chk("R9 gpo kept", d, 16'h1234);
    chk("R9 no pulse", 16'(shutdown_req), 16'h0);

    // R11 write cycle leaves rdata zero
    bus_sel = 1; bus_we = 1; bus_addr = 6'h32; bus_wdata = 16'h0;
    #1 chk("R11 write rdata", bus_rdata, 16'h0);
    @(negedge clk); bus_sel = 0; bus_we = 0;

    // R10 reset again
    rst_n = 0;
    @(negedge clk);
    chk("R10 gpo again", gpo, 16'h0);
    chk("R10 code again", 16'(irl_code), 16'h0);
    rst_n = 1;
    @(negedge clk);
    rd(6'h00, d); chk("R10 mask again", d, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule